// File: doc/BRIEF.md
# Strict-Inequality Gate Network Search Engine

This block searches, by brute force, for the smallest tree of two-input "less-than" gates that reproduces a given Boolean function of three inputs. Each gate outputs 1 only when its left operand is 0 and its right operand is 1. Each leaf of the tree is one of the three primary inputs or the constant 1, and the constant costs nothing. The function is supplied as an 8-bit truth table. After a start pulse the engine tries every candidate of one gate, then of two gates, and so on up to a gate limit. It stops at the first candidate whose truth table equals the target, so the reported network is minimal in gate count.

Each candidate is held as a postfix string of leaves and gates. The string is evaluated one symbol per cycle on a small stack whose entries are whole 8-bit truth-table words, so all eight input rows are computed at once. An optional depth limit rejects trees whose longest leaf-to-root path is too long. The result is given as a gate count, a shape number and one 2-bit selector per leaf.

Top module: `ltnet_search`

## Requirements
- R1: A gate with left operand word A and right operand word B yields (~A) & B bitwise. The left operand is the subtree written first in postfix order. Cost is the number of gates, and a constant-1 leaf adds nothing to it.
- R2: Leaf selector codes are 0 = input x0 (word 0xF0), 1 = x1 (0xCC), 2 = x2 (0xAA) and 3 = constant 1 (0xFF). Leaves are numbered left to right in postfix order. The selector of leaf j sits at leaf_sel[2j+1:2j], and the fields of leaves the result does not use read zero.
- R3: When the target equals one of the four leaf words, done pulses in the cycle after the clock edge that samples start. The result is then found=1, gates=0, shape_id=0 and leaf_sel equal to that leaf's code, and busy stays low.
- R4: Candidates are tried in this order: gate count rising from 1; within a count, shape_id rising; within a shape, the leaf assignment rising as a base-4 number whose least significant digit is leaf 0. The first match is the one reported.
- R5: A shape with M gates is a postfix string of 2M+1 symbols, where bit i of its code is 1 when symbol i is a gate. shape_id is the rank of that code among the valid strings in ascending numeric order. There are 1, 2, 5 and 14 shapes for M = 1 to 4.
- R6: Each candidate with M gates takes 2M+1 cycles. For a search, busy rises after the edge that samples start, and done pulses for one cycle S edges after that edge, where S is the total symbol count of all candidates tried, including the matching one. busy falls in the same cycle that done rises.
- R7: max_gates values above 4 act as 4. With max_gates = 0 and a target that is not a leaf word, done pulses in the next cycle with found=0.
- R8: A nonzero max_depth rejects any candidate whose depth, counted in gates on the longest leaf-to-root path, exceeds it. A max_depth of 0 sets no limit.
- R9: When no candidate within the gate limit matches, done pulses after all of them have been tried, with found=0 and gates, shape_id and leaf_sel all zero.
- R10: A start pulse while busy is high is ignored. It changes neither the result nor its timing.
- R11: After reset, busy, done and found are low and gates, shape_id and leaf_sel are zero.
- R12: An accepted start clears found, gates, shape_id and leaf_sel, and found stays low while busy. The result stays stable after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a search when the engine is idle |
| target | input | 8 | Truth table of the wanted function |
| max_gates | input | 3 | Largest gate count to try (0 to 4; larger values clamp to 4) |
| max_depth | input | 3 | Largest allowed tree depth; 0 means no limit |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when the search ends |
| found | output | 1 | A matching network was found |
| gates | output | 3 | Gate count of the reported network |
| shape_id | output | 4 | Shape rank of the reported network |
| leaf_sel | output | 10 | Per-leaf selectors, 2 bits per leaf |

## Verification
The bench works out, for each stimulus, how many edges after the sampling edge the done pulse is due. This is zero for leaf-word targets and for a zero gate limit. Otherwise it is the sum of 2M+1 over every candidate up to and including the match, or over the whole space when nothing matches. The bench counts these candidates in its own enumeration. On every clock in between it compares busy, done and found with that schedule, sampling at the falling edge. It reads the result fields in the done cycle and again one cycle later, to confirm that they are held.

// File: rtl/ltnet_pkg.sv
package ltnet_pkg;

    localparam int NUM_IN   = 3;
    localparam int TT_W     = 1 << NUM_IN;
    localparam int GATE_MAX = 4;
    localparam int LEAF_MAX = GATE_MAX + 1;
    localparam int NODE_MAX = 2 * GATE_MAX + 1;
    localparam int SEL_W    = 2;
    localparam int NUM_SEL  = 1 << SEL_W;
    localparam int LSEL_W   = SEL_W * LEAF_MAX;
    localparam int CNT_W    = $clog2(GATE_MAX + 1) < 3 ? 3 : $clog2(GATE_MAX + 1);
    localparam int NODE_W   = $clog2(NODE_MAX + 1);
    localparam int LPTR_W   = $clog2(LEAF_MAX + 1);
    localparam int DEP_W    = 3;

    typedef logic [TT_W-1:0]     tt_t;
    typedef logic [NODE_MAX-1:0] pat_t;

    // number of binary tree shapes with m internal nodes
    function automatic int catalan(input int m);
        int c;
        c = 1;
        for (int i = 0; i < m; i++) c = c * 2 * (2 * i + 1) / (i + 2);
        return c;
    endfunction

    // first flat table slot used by shapes of gate count m
    function automatic int shape_base(input int m);
        int b;
        b = 0;
        for (int g = 1; g < m; g++) b = b + catalan(g);
        return b;
    endfunction

    localparam int SHAPE_TOT = shape_base(GATE_MAX + 1);
    localparam int SHID_W    = $clog2(catalan(GATE_MAX));

    // idx-th valid postfix code (bit set = gate) with m gates, ascending
    function automatic pat_t shape_pat(input int m, input int idx);
        int   seen;
        int   h;
        int   g;
        bit   ok;
        pat_t res;
        seen = 0;
        res  = '0;
        for (int p = 0; p < (1 << (2 * m + 1)); p++) begin
            h  = 0;
            g  = 0;
            ok = 1'b1;
            for (int i = 0; i < 2 * m + 1; i++) begin
                if (p[i]) begin
                    if (h < 2) ok = 1'b0;
                    h = h - 1;
                    g = g + 1;
                end else begin
                    h = h + 1;
                end
            end
            if (ok && h == 1 && g == m) begin
                if (seen == idx) res = pat_t'(p);
                seen = seen + 1;
            end
        end
        return res;
    endfunction

    // truth-table word of a leaf selector; codes >= NUM_IN give constant 1
    function automatic tt_t leaf_word(input logic [SEL_W-1:0] sel);
        tt_t               w;
        logic [NUM_IN-1:0] row;
        w = '0;
        for (int r = 0; r < TT_W; r++) begin
            row = NUM_IN'(r);
            if (int'(sel) >= NUM_IN) w[r] = 1'b1;
            else                     w[r] = row[NUM_IN-1-int'(sel)];
        end
        return w;
    endfunction

endpackage

// File: rtl/ltnet_shape_rom.sv
module ltnet_shape_rom
    import ltnet_pkg::*;
(
    input  logic [CNT_W-1:0]  m,
    input  logic [SHID_W-1:0] idx,
    output pat_t              pat,
    output logic              last
);

    pat_t table_w [SHAPE_TOT];

    for (genvar g = 1; g <= GATE_MAX; g++) begin : g_cnt
        localparam int BASE = shape_base(g);
        localparam int NSH  = catalan(g);
        for (genvar s = 0; s < NSH; s++) begin : g_shp
            localparam pat_t PAT = shape_pat(g, s);
            assign table_w[BASE+s] = PAT;
        end
    end

    always_comb begin
        pat  = '0;
        last = 1'b1;
        for (int g = 1; g <= GATE_MAX; g++) begin
            if (m == CNT_W'(g)) begin
                last = (int'(idx) == catalan(g) - 1);
                for (int e = 0; e < SHAPE_TOT; e++) begin
                    if (e == shape_base(g) + int'(idx)) pat = table_w[e];
                end
            end
        end
    end

endmodule

// File: rtl/ltnet_stack.sv
module ltnet_stack
    import ltnet_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             first,
    input  logic             is_gate,
    input  tt_t              leaf_w,
    output tt_t              fold_w,
    output logic [DEP_W-1:0] fold_d
);

    typedef struct packed {
        tt_t [LEAF_MAX-1:0]              val;
        logic [LEAF_MAX-1:0][DEP_W-1:0]  dep;
        logic [LPTR_W-1:0]               sp;
    } stk_t;

    stk_t              s_d, s_q;
    tt_t               a_w, b_w;
    logic [DEP_W-1:0]  a_d, b_d;
    logic [LPTR_W-1:0] sp_eff;

    // combine the two topmost entries as one gate
    always_comb begin
        a_w = '0;
        b_w = '0;
        a_d = '0;
        b_d = '0;
        for (int i = 0; i < LEAF_MAX; i++) begin
            if (int'(s_q.sp) == i + 2) begin
                a_w = s_q.val[i];
                a_d = s_q.dep[i];
            end
            if (int'(s_q.sp) == i + 1) begin
                b_w = s_q.val[i];
                b_d = s_q.dep[i];
            end
        end
        fold_w = ~a_w & b_w;
        fold_d = ((a_d > b_d) ? a_d : b_d) + DEP_W'(1);
    end

    always_comb begin
        s_d    = s_q;
        sp_eff = first ? '0 : s_q.sp;
        if (step) begin
            if (is_gate) begin
                for (int i = 0; i < LEAF_MAX; i++) begin
                    if (int'(s_q.sp) == i + 2) begin
                        s_d.val[i] = fold_w;
                        s_d.dep[i] = fold_d;
                    end
                end
                s_d.sp = s_q.sp - LPTR_W'(1);
            end else begin
                for (int i = 0; i < LEAF_MAX; i++) begin
                    if (int'(sp_eff) == i) begin
                        s_d.val[i] = leaf_w;
                        s_d.dep[i] = '0;
                    end
                end
                s_d.sp = sp_eff + LPTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_GATE_HAS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        step && is_gate |-> !first && s_q.sp >= LPTR_W'(2)); // R5
    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        step && !is_gate && !first |-> s_q.sp < LPTR_W'(LEAF_MAX)); // R5

endmodule

// File: rtl/ltnet_search.sv
module ltnet_search
    import ltnet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TT_W-1:0]   target,
    input  logic [CNT_W-1:0]  max_gates,
    input  logic [DEP_W-1:0]  max_depth,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [CNT_W-1:0]  gates,
    output logic [SHID_W-1:0] shape_id,
    output logic [LSEL_W-1:0] leaf_sel
);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  m;
        logic [CNT_W-1:0]  lim_g;
        logic [DEP_W-1:0]  lim_d;
        tt_t               tgt;
        logic [SHID_W-1:0] shp;
        logic [LSEL_W-1:0] leaf;
        logic [NODE_W-1:0] node;
        logic [LPTR_W-1:0] lptr;
        logic              done;
        logic              found;
        logic [CNT_W-1:0]  gates;
        logic [SHID_W-1:0] shape_id;
        logic [LSEL_W-1:0] leaf_sel;
    } ctl_t;

    ctl_t             d, q;
    pat_t             pat;
    logic             shp_last;
    logic             elem_gate;
    logic [SEL_W-1:0] cur_sel;
    tt_t              leaf_w;
    tt_t              fold_w;
    logic [DEP_W-1:0] fold_d;
    logic             last_node;
    logic             leaf_last;
    logic             match;
    logic             triv_hit;
    logic [SEL_W-1:0] triv_code;
    logic [CNT_W-1:0] lim_in;

    ltnet_shape_rom u_rom (
        .m    (q.m),
        .idx  (q.shp),
        .pat  (pat),
        .last (shp_last)
    );

    ltnet_stack u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (q.st == ST_RUN),
        .first   (q.node == '0),
        .is_gate (elem_gate),
        .leaf_w  (leaf_w),
        .fold_w  (fold_w),
        .fold_d  (fold_d)
    );

    // decode the current postfix symbol and leaf selector
    always_comb begin
        elem_gate = 1'b0;
        for (int i = 0; i < NODE_MAX; i++) begin
            if (int'(q.node) == i) elem_gate = pat[i];
        end
        cur_sel = '0;
        for (int j = 0; j < LEAF_MAX; j++) begin
            if (int'(q.lptr) == j) cur_sel = q.leaf[SEL_W*j +: SEL_W];
        end
        leaf_w = leaf_word(cur_sel);
        leaf_last = 1'b1;
        for (int j = 0; j < LEAF_MAX; j++) begin
            if (j <= int'(q.m) && q.leaf[SEL_W*j +: SEL_W] != {SEL_W{1'b1}}) leaf_last = 1'b0;
        end
        last_node = (q.node == NODE_W'({q.m, 1'b0}));
        match     = (fold_w == q.tgt) && (q.lim_d == '0 || fold_d <= q.lim_d);
        triv_hit  = 1'b0;
        triv_code = '0;
        for (int c = 0; c < NUM_SEL; c++) begin
            if (target == leaf_word(SEL_W'(c))) begin
                triv_hit  = 1'b1;
                triv_code = SEL_W'(c);
            end
        end
        lim_in = (max_gates > CNT_W'(GATE_MAX)) ? CNT_W'(GATE_MAX) : max_gates;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.found    = 1'b0;
                    d.gates    = '0;
                    d.shape_id = '0;
                    d.leaf_sel = '0;
                    d.tgt      = target;
                    d.lim_g    = lim_in;
                    d.lim_d    = max_depth;
                    d.m        = CNT_W'(1);
                    d.shp      = '0;
                    d.leaf     = '0;
                    d.node     = '0;
                    d.lptr     = '0;
                    if (triv_hit) begin
                        d.done     = 1'b1;
                        d.found    = 1'b1;
                        d.leaf_sel = LSEL_W'(triv_code);
                    end else if (lim_in == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_RUN;
                    end
                end
            end
            default: begin
                d.node = q.node + NODE_W'(1);
                if (!elem_gate) d.lptr = q.lptr + LPTR_W'(1);
                if (last_node) begin
                    d.node = '0;
                    d.lptr = '0;
                    if (match) begin
                        d.st       = ST_IDLE;
                        d.done     = 1'b1;
                        d.found    = 1'b1;
                        d.gates    = q.m;
                        d.shape_id = q.shp;
                        d.leaf_sel = q.leaf;
                    end else if (!leaf_last) begin
                        d.leaf = q.leaf + LSEL_W'(1);
                    end else begin
                        d.leaf = '0;
                        if (!shp_last) begin
                            d.shp = q.shp + SHID_W'(1);
                        end else begin
                            d.shp = '0;
                            if (q.m == q.lim_g) begin
                                d.st   = ST_IDLE;
                                d.done = 1'b1;
                            end else begin
                                d.m = q.m + CNT_W'(1);
                            end
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st == ST_RUN);
    assign done     = q.done;
    assign found    = q.found;
    assign gates    = q.gates;
    assign shape_id = q.shape_id;
    assign leaf_sel = q.leaf_sel;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_FOUND_CLEAR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !found); // R12
    AST_GATES_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done && found |-> gates <= q.lim_g); // R7
    AST_COUNT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> q.m >= $past(q.m)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(q.tgt)); // R10
    AST_UNUSED_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && found |-> (leaf_sel >> (SEL_W * (int'(gates) + 1))) == '0); // R2

endmodule

// File: tb/sim_ltnet_search.sv
`timescale 1ns/1ps
module sim_ltnet_search;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] target = 8'h00;
    logic [2:0] max_gates = 3'd0;
    logic [2:0] max_depth = 3'd0;
    logic       busy, done, found;
    logic [2:0] gates;
    logic [3:0] shape_id;
    logic [9:0] leaf_sel;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    ltnet_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .max_gates(max_gates), .max_depth(max_depth), .busy(busy), .done(done),
        .found(found), .gates(gates), .shape_id(shape_id), .leaf_sel(leaf_sel)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run still active actual=%0d expected<190000 cycles", cyc);
            finish_run();
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // behavioural search following the requirement ordering (R1,R2,R4,R5,R7,R8)
    task automatic model(input logic [7:0] t, input int mg_in, input int md,
                         output bit f, output int g, output int sh, output int lv, output int lat);
        int words[4];
        int vq[$];
        int dq[$];
        int mg, h, gc, sidx, li, b, a, bd, ad;
        bit ok;
        words[0] = 'hF0; words[1] = 'hCC; words[2] = 'hAA; words[3] = 'hFF;
        f = 0; g = 0; sh = 0; lv = 0; lat = 0;
        for (int c = 0; c < 4; c++) begin
            if (int'(t) == words[c]) begin
                f = 1; lv = c;
                return;
            end
        end
        mg = (mg_in > 4) ? 4 : mg_in;
        for (int m = 1; m <= mg; m++) begin
            sidx = 0;
            for (int p = 0; p < (1 << (2 * m + 1)); p++) begin
                h = 0; gc = 0; ok = 1;
                for (int i = 0; i < 2 * m + 1; i++) begin
                    if (p[i]) begin
                        if (h < 2) ok = 0;
                        h--; gc++;
                    end else h++;
                end
                if (!(ok && h == 1 && gc == m)) continue;
                for (int asg = 0; asg < (1 << (2 * (m + 1))); asg++) begin
                    vq.delete(); dq.delete(); li = 0;
                    lat += 2 * m + 1;
                    for (int i = 0; i < 2 * m + 1; i++) begin
                        if (p[i]) begin
                            b = vq.pop_back(); a = vq.pop_back();
                            bd = dq.pop_back(); ad = dq.pop_back();
                            vq.push_back((~a & b) & 'hFF);
                            dq.push_back(((ad > bd) ? ad : bd) + 1);
                        end else begin
                            vq.push_back(words[(asg >> (2 * li)) & 3]);
                            dq.push_back(0);
                            li++;
                        end
                    end
                    if (vq[0] == int'(t) && (md == 0 || dq[0] <= md)) begin
                        f = 1; g = m; sh = sidx; lv = asg;
                        return;
                    end
                end
                sidx++;
            end
        end
    endtask

    // poke >= 0: a second start with other inputs is driven during the search (R10)
    task automatic run_case(input string name, input logic [7:0] t, input int mg,
                            input int md, input int poke);
        bit f;
        int g, sh, lv, lat;
        model(t, mg, md, f, g, sh, lv, lat);
        @(negedge clk);
        target = t; max_gates = mg[2:0]; max_depth = md[2:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= lat; j++) begin
            if (j > 0) @(negedge clk);
            chk({name, " R6 busy"}, int'(busy), int'(j < lat));
            chk({name, " R6 done"}, int'(done), int'(j == lat));
            if (j < lat) chk({name, " R12 found low while busy"}, int'(found), 0);
            if (j == poke && j < lat) begin
                start = 1'b1; target = ~t; max_gates = 3'd1; max_depth = 3'd1;
            end else begin
                start = 1'b0;
            end
        end
        chk({name, " R4 found"}, int'(found), int'(f));
        chk({name, " R4 gates"}, int'(gates), g);
        chk({name, " R5 shape_id"}, int'(shape_id), sh);
        chk({name, " R2 leaf_sel"}, int'(leaf_sel), lv);
        @(negedge clk);
        chk({name, " R6 done is a pulse"}, int'(done), 0);
        chk({name, " R12 result held"}, int'({found, gates, shape_id, leaf_sel}),
            int'({f, 3'(g), 4'(sh), 10'(lv)}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 done after reset", int'(done), 0);
        chk("R11 result after reset", int'({found, gates, shape_id, leaf_sel}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case("R3 x1 leaf", 8'hCC, 4, 0, -1);
        run_case("R3 const1 leaf", 8'hFF, 4, 0, -1);
        run_case("R3 x2 leaf", 8'hAA, 0, 0, -1);
        run_case("R1 zero from one gate", 8'h00, 4, 0, -1);
        run_case("R1 x1<x0", 8'h30, 4, 0, -1);
        run_case("R1 x0<x1 operand order", 8'h0C, 4, 0, -1);
        run_case("R1 not x0", 8'h0F, 4, 0, -1);
        run_case("R4 and x0 x1", 8'hC0, 4, 0, -1);
        run_case("R4 or x0 x2", 8'hFA, 3, 0, -1);
        run_case("R8 or with depth 2", 8'hFA, 3, 2, -1);
        run_case("R8 and with depth 2", 8'hC0, 4, 2, -1);
        run_case("R9 xor not reachable", 8'h3C, 3, 0, -1);
        run_case("R7 zero limit", 8'hC0, 0, 0, -1);
        run_case("R7 limit clamps", 8'hC0, 7, 0, -1);
        run_case("R10 start while busy", 8'hFA, 3, 0, 5);
        run_case("R12 new start after result", 8'h30, 2, 0, -1);

        finish_run();
    end

endmodule